// File: doc/BRIEF.md
# Dual-Granularity SPI Serial Clock Divider

This block derives the serial clock timing of an SPI master from its reference clock. It does not produce a second clock domain. It runs a single counter in the reference domain and emits one-cycle strobes: one where the serial clock makes its leading edge, one where it makes its trailing edge, and a toggle strobe for either edge. It also emits a half-period tick that chip-select timing logic can count while no data moves, and a registered serial clock level for the pad.

The division ratio comes from a 4-bit divide code and an 8-bit extension code, under a granularity select. With the select low, the ratio is a power of two chosen by the divide code alone. With the select high, the extension supplies the upper 8 bits and the divide code the lower 4 bits of a 12-bit value. The ratio is that value plus one, which gives steps of one reference cycle. The shift engine pulses a word-start input to load the ratio, and raises a run input while it wants clock edges. Dropping the enable, which the channel holds high only in master mode, parks the counter and the serial clock.

Top module: `spi_clkdiv_gen`

## Requirements
- R1: With gran_sel = 0, the ratio N is 2^div_code, so code 0 gives N = 1 and code 15 gives N = 32768. While run stays high, lead_stb pulses once every N reference cycles, and the first pulse comes in the first run cycle after word_start.
- R2: With gran_sel = 1, N = {div_ext, div_code} + 1, with div_ext as the upper 8 bits, so N ranges from 1 to 4096. The lead_stb spacing is N cycles, as in R1.
- R3: trail_stb pulses floor(N/2) cycles after each lead_stb. For odd N, the active phase is therefore one reference cycle shorter than the idle phase. For N = 1, both strobes pulse in every cycle.
- R4: sclk_o equals idle_pol, except in the cycles after a leading edge and up to and including the cycle of the next trailing edge, where it is the inverse of idle_pol. When both edges fall in the same cycle (N = 1), sclk_o stays at idle_pol.
- R5: toggle_stb is high exactly in the cycles where lead_stb or trail_stb is high.
- R6: While enable is high, half_tick pulses at both half-period points: period offset 0 and offset floor(N/2). It does so whether or not run is high.
- R7: lead_stb, trail_stb and toggle_stb stay low while run is low. sclk_o then stays at idle_pol.
- R8: While enable is low, all strobes are low and the counter is held at offset 0. sclk_o is at idle_pol from the next cycle onward. Once enable rises again with run high, lead_stb pulses in the first cycle. The latched ratio is kept across the disable.
- R9: gran_sel, div_code and div_ext are loaded only by a word_start pulse while enable is high. A change to them at any other time does not alter the strobe spacing of the word in progress.
- R10: After reset, all strobes are low and sclk_o equals idle_pol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enabled as master; low parks the divider |
| run | input | 1 | Shift engine requests serial clock edges |
| word_start | input | 1 | One-cycle pulse: load the ratio and restart the period |
| gran_sel | input | 1 | 0 = power-of-two ratio, 1 = one-cycle-step ratio |
| div_code | input | 4 | Divide code (exponent, or the low 4 bits of the linear value) |
| div_ext | input | 8 | Extension code (the high 8 bits of the linear value) |
| idle_pol | input | 1 | Serial clock level when idle |
| sclk_o | output | 1 | Registered serial clock level |
| lead_stb | output | 1 | Leading edge happens at the end of this cycle |
| trail_stb | output | 1 | Trailing edge happens at the end of this cycle |
| toggle_stb | output | 1 | Either edge happens at the end of this cycle |
| half_tick | output | 1 | Half-period boundary tick |

## Verification
The hardest situations to reach are the extreme ratios. The largest power-of-two code needs 32768 cycles for a single period, and the largest linear value needs 4096 cycles per period. Odd linear ratios are needed to expose the unequal phases. The stimulus sweeps every power-of-two code for one full period and every linear value from 0 to 63 for two periods, then runs the 4096 ratio. Every cycle of each window is compared with offsets computed from the period arithmetic. Reprogramming in the middle of a word and disabling in the middle of an active phase are each driven at a chosen negative edge, so that their effect falls in a known cycle.

// File: rtl/spi_clkdiv_pkg.sv
// Package: types shared by the SPI serial clock divider.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_clkdiv_pkg;
    typedef enum logic {
        GRAN_POW2   = 1'b0,
        GRAN_LINEAR = 1'b1
    } gran_e;
endpackage

// File: rtl/spi_clkdiv_ratio.sv
// Ratio former: turns the granularity select, divide code and extension
// into the number of reference cycles per serial clock period.
// Assumes: RATIO_W is wide enough for 2**(2**CODE_W - 1) and for
// 2**(CODE_W+EXT_W); the top module derives it that way.
module spi_clkdiv_ratio
    import spi_clkdiv_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int EXT_W   = 8,
    parameter int RATIO_W = 16
) (
    input  logic               gran_sel,
    input  logic [CODE_W-1:0]  div_code,
    input  logic [EXT_W-1:0]   div_ext,
    output logic [RATIO_W-1:0] ratio
);
    localparam int POW_N = 2 ** CODE_W;
    localparam int LIN_W = CODE_W + EXT_W;

    logic [RATIO_W-1:0] pow_ratio;
    logic [RATIO_W-1:0] lin_ratio;
    logic [POW_N-1:0]   code_hot;

    // One decode line per power-of-two exponent.
    for (genvar i = 0; i < POW_N; i++) begin : g_pow
        assign code_hot[i] = (div_code == CODE_W'(i));
    end

    // Power-of-two ratio: the decoded exponent, zero-extended.
    always_comb begin
        pow_ratio = '0;
        pow_ratio[POW_N-1:0] = code_hot;
    end

    // Linear ratio: extension above the code, plus one.
    always_comb begin
        lin_ratio = RATIO_W'({div_ext, div_code}) + RATIO_W'(1);
    end

    // Granularity select between the two forms.
    always_comb begin
        if (gran_e'(gran_sel) == GRAN_LINEAR) begin
            ratio = lin_ratio;
        end else begin
            ratio = pow_ratio;
        end
    end

    logic unused_w;
    assign unused_w = (LIN_W < 1);
endmodule

// File: rtl/spi_clkdiv_counter.sv
// Period counter: holds the latched ratio and counts the reference cycles
// of the current serial clock period, from 0 to ratio-1.
// Assumes: a ratio of at least 1 is presented at word start.
module spi_clkdiv_counter #(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               word_start,
    input  logic [RATIO_W-1:0] ratio_nxt,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [RATIO_W-1:0] cnt_q
);
    logic at_wrap;

    // Last offset of the period.
    assign at_wrap = (cnt_q == ratio_q - RATIO_W'(1));

    // Ratio latch: loaded only at word start while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= RATIO_W'(1);
        end else if (enable && word_start) begin
            ratio_q <= ratio_nxt;
        end
    end

    // Offset counter: parked at 0 while disabled, restarted at word start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || word_start || at_wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
        end
    end
endmodule

// File: rtl/spi_clkdiv_edges.sv
// Edge generator: decodes the period offset into leading and trailing edge
// strobes, the half-period tick and the registered serial clock level.
// Assumes: cnt_q runs from 0 to ratio_q-1; the leading edge is at offset 0
// and the trailing edge at offset floor(ratio_q/2).
module spi_clkdiv_edges #(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               run,
    input  logic               idle_pol,
    input  logic [RATIO_W-1:0] ratio_q,
    input  logic [RATIO_W-1:0] cnt_q,
    output logic               lead_stb,
    output logic               trail_stb,
    output logic               toggle_stb,
    output logic               half_tick,
    output logic               sclk_o
);
    logic [RATIO_W-1:0] half_off;
    logic               at_lead;
    logic               at_trail;
    logic               active_q;

    // Offset of the trailing edge.
    assign half_off = ratio_q >> 1;

    // Raw offset decodes, qualified by enable.
    assign at_lead  = enable && (cnt_q == '0);
    assign at_trail = enable && (cnt_q == half_off);

    // Strobes toward the shift engine and the chip-select timer.
    always_comb begin
        lead_stb   = run && at_lead;
        trail_stb  = run && at_trail;
        toggle_stb = lead_stb || trail_stb;
        half_tick  = at_lead || at_trail;
    end

    // Active-phase flag: set by a lone leading edge, cleared by a trailing one.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            active_q <= 1'b0;
        end else if (trail_stb) begin
            active_q <= 1'b0;
        end else if (lead_stb) begin
            active_q <= 1'b1;
        end
    end

    // Pad level: the active flag folded with the idle polarity.
    assign sclk_o = active_q ^ idle_pol;
endmodule

// File: rtl/spi_clkdiv_gen.sv
// Top: SPI master serial clock divider with power-of-two or one-cycle-step
// ratio. Produces edge strobes in the reference clock domain.
// Assumes: word_start is a one-cycle pulse from the shift engine; the
// configuration inputs are stable in the word_start cycle.
module spi_clkdiv_gen #(
    parameter int CODE_W = 4,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              run,
    input  logic              word_start,
    input  logic              gran_sel,
    input  logic [CODE_W-1:0] div_code,
    input  logic [EXT_W-1:0]  div_ext,
    input  logic              idle_pol,
    output logic              sclk_o,
    output logic              lead_stb,
    output logic              trail_stb,
    output logic              toggle_stb,
    output logic              half_tick
);
    localparam int POW_W   = 2 ** CODE_W;
    localparam int LIN_W   = CODE_W + EXT_W + 1;
    localparam int RATIO_W = (POW_W > LIN_W) ? POW_W : LIN_W;

    logic [RATIO_W-1:0] ratio_nxt;
    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] cnt_q;

    spi_clkdiv_ratio #(
        .CODE_W (CODE_W),
        .EXT_W  (EXT_W),
        .RATIO_W(RATIO_W)
    ) u_ratio (
        .gran_sel(gran_sel),
        .div_code(div_code),
        .div_ext (div_ext),
        .ratio   (ratio_nxt)
    );

    spi_clkdiv_counter #(
        .RATIO_W(RATIO_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .word_start(word_start),
        .ratio_nxt (ratio_nxt),
        .ratio_q   (ratio_q),
        .cnt_q     (cnt_q)
    );

    spi_clkdiv_edges #(
        .RATIO_W(RATIO_W)
    ) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .run       (run),
        .idle_pol  (idle_pol),
        .ratio_q   (ratio_q),
        .cnt_q     (cnt_q),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb),
        .toggle_stb(toggle_stb),
        .half_tick (half_tick)
        ,.sclk_o   (sclk_o)
    );
endmodule

// File: rtl/spi_clkdiv_chk.sv
// Checker: watches the ports of spi_clkdiv_gen and checks edge timing
// against a ratio it forms itself from the configuration seen at word start.
// Assumes: attached by the bind statement at the end of this file.
module spi_clkdiv_chk #(
    parameter int CODE_W = 4,
    parameter int EXT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              run,
    input logic              word_start,
    input logic              gran_sel,
    input logic [CODE_W-1:0] div_code,
    input logic [EXT_W-1:0]  div_ext,
    input logic              idle_pol,
    input logic              sclk_o,
    input logic              lead_stb,
    input logic              trail_stb,
    input logic              toggle_stb,
    input logic              half_tick
);
    localparam int GAP_W = (2 ** CODE_W > CODE_W + EXT_W + 1)
                         ? 2 ** CODE_W + 1 : CODE_W + EXT_W + 2;

    logic [GAP_W-1:0] exp_n;
    logic [GAP_W-1:0] gap;
    logic             gap_valid;

    // Expected ratio, formed from the ports at word start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_n <= GAP_W'(1);
        end else if (enable && word_start) begin
            if (gran_sel) begin
                exp_n <= GAP_W'(div_ext) * GAP_W'(2 ** CODE_W) + GAP_W'(div_code) + GAP_W'(1);
            end else begin
                exp_n <= GAP_W'(1) << div_code;
            end
        end
    end

    // Cycles since the last leading edge of an unbroken run.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !run || word_start) begin
            gap       <= '0;
            gap_valid <= 1'b0;
        end else if (lead_stb) begin
            gap       <= GAP_W'(1);
            gap_valid <= 1'b1;
        end else begin
            gap       <= gap + GAP_W'(1);
        end
    end

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb && gap_valid) |-> (gap == exp_n)); // R1
    AST_TRAIL_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_stb && !lead_stb && gap_valid) |-> (gap == (exp_n >> 1))); // R3
    AST_LEAD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb && !trail_stb) |=> (sclk_o != idle_pol)); // R4
    AST_TRAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |=> (sclk_o == idle_pol)); // R4
    AST_TOGGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_stb |-> (lead_stb || trail_stb)); // R5
    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb || trail_stb) |-> half_tick); // R6
    AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!lead_stb && !trail_stb && !toggle_stb)); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!lead_stb && !trail_stb && !half_tick)); // R8
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (sclk_o == idle_pol)); // R8
endmodule

bind spi_clkdiv_gen spi_clkdiv_chk #(
    .CODE_W(CODE_W),
    .EXT_W (EXT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .run       (run),
    .word_start(word_start),
    .gran_sel  (gran_sel),
    .div_code  (div_code),
    .div_ext   (div_ext),
    .idle_pol  (idle_pol),
    .sclk_o    (sclk_o),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .toggle_stb(toggle_stb),
    .half_tick (half_tick)
);

// File: tb/test_spi_clkdiv_gen.sv
// Bench: sweeps ratios of both granularities and compares every cycle with
// offsets computed from the period arithmetic.
module test_spi_clkdiv_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       run = 1'b0;
    logic       word_start = 1'b0;
    logic       gran_sel = 1'b0;
    logic [3:0] div_code = '0;
    logic [7:0] div_ext = '0;
    logic       idle_pol = 1'b0;
    logic       sclk_o;
    logic       lead_stb;
    logic       trail_stb;
    logic       toggle_stb;
    logic       half_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    spi_clkdiv_gen i_spi_clkdiv_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .run       (run),
        .word_start(word_start),
        .gran_sel  (gran_sel),
        .div_code  (div_code),
        .div_ext   (div_ext),
        .idle_pol  (idle_pol),
        .sclk_o    (sclk_o),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb),
        .toggle_stb(toggle_stb),
        .half_tick (half_tick)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Set the configuration and pulse word_start; returns at the negedge
    // after the load with run driven to r.
    task automatic start_word(input bit g, input int code, input int ext, input bit r);
        gran_sel   = g;
        div_code   = 4'(code);
        div_ext    = 8'(ext);
        run        = 1'b0;
        word_start = 1'b1;
        @(negedge clk);
        word_start = 1'b0;
        run        = r;
    endtask

    // Compare cyc cycles of outputs with a ratio-n period starting at offset 0.
    task automatic window(input int n, input int cyc, input bit r, input string tag);
        int  bad = 0;
        int  act = 0;
        int  exp = 0;
        int  h = n / 2;
        for (int p = 0; p < cyc; p++) begin
            int q = p % n;
            bit e_lead = r && (q == 0);
            bit e_trail = r && (q == h);
            bit e_tog = e_lead || e_trail;
            bit e_half = (q == 0) || (q == h);
            bit e_sclk = idle_pol;
            #1;
            if (r && n > 1 && p >= 1 && ((p - 1) % n) < h) e_sclk = ~idle_pol;
            if ({lead_stb, trail_stb, toggle_stb, half_tick, sclk_o} !=
                {e_lead, e_trail, e_tog, e_half, e_sclk}) begin
                if (bad == 0) begin
                    act = {27'd0, lead_stb, trail_stb, toggle_stb, half_tick, sclk_o};
                    exp = {27'd0, e_lead, e_trail, e_tog, e_half, e_sclk};
                end
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, $sformatf("%s n=%0d {lead,trail,tog,half,sclk}", tag, n), act, exp);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: quiet outputs, idle level after reset
        check({lead_stb, trail_stb, toggle_stb, half_tick} == 4'b0, "R10 strobes after reset",
              {lead_stb, trail_stb, toggle_stb, half_tick}, 0);
        check(sclk_o == idle_pol, "R10 sclk after reset", sclk_o, idle_pol);
        @(negedge clk);
        enable = 1'b1;

        // R1 and R4/R5: every power-of-two code, one period each (R3 trail at n/2)
        for (int c = 0; c < 16; c++) begin
            start_word(1'b0, c, 8'hA5, 1'b1);
            window(1 << c, (c == 0) ? 4 : (1 << c), 1'b1, "R1 R3 R4 R5 pow2");
        end

        // R2 and R3: linear values 0..63 with odd and even ratios, two periods
        for (int v = 0; v < 64; v++) begin
            start_word(1'b1, v % 16, v / 16, 1'b1);
            window(v + 1, 2 * (v + 1), 1'b1, "R2 R3 R4 R5 linear");
        end

        // R2: the largest linear ratio
        start_word(1'b1, 15, 255, 1'b1);
        window(4096, 4096, 1'b1, "R2 linear max");

        // R4 with inverted idle level, odd ratio
        idle_pol = 1'b1;
        start_word(1'b1, 6, 0, 1'b1);
        window(7, 14, 1'b1, "R4 idle high");
        idle_pol = 1'b0;

        // R6 and R7: ticks continue, edges stop while run is low
        start_word(1'b1, 4, 0, 1'b0);
        window(5, 15, 1'b0, "R6 R7 run low");

        // R9: configuration changed mid word is ignored until the next word start
        start_word(1'b1, 5, 0, 1'b1);
        div_code = 4'd1;
        gran_sel = 1'b0;
        div_ext  = 8'd3;
        window(6, 18, 1'b1, "R9 change ignored");
        start_word(1'b0, 1, 3, 1'b1);
        window(2, 8, 1'b1, "R9 new ratio at word start");

        // R8: disable mid active phase, then resume at offset 0
        start_word(1'b1, 3, 0, 1'b1);
        window(4, 5, 1'b1, "R8 before disable");
        check(sclk_o != idle_pol, "R8 active before disable", sclk_o, ~idle_pol);
        enable = 1'b0;
        #1;
        check({lead_stb, trail_stb, toggle_stb, half_tick} == 4'b0, "R8 strobes when disabled",
              {lead_stb, trail_stb, toggle_stb, half_tick}, 0);
        @(negedge clk);
        #1;
        check(sclk_o == idle_pol, "R8 sclk idle after disable", sclk_o, idle_pol);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        window(4, 8, 1'b1, "R8 resume at offset 0");

        // R9: word_start while disabled does not load a ratio
        enable = 1'b0;
        start_word(1'b1, 9, 0, 1'b1);
        enable = 1'b1;
        window(4, 8, 1'b1, "R9 word start ignored while disabled");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule